// File: doc/BRIEF.md
# L2 MAC-VID Hash Bucket Lookup Engine

This block finds or creates the layer-2 forwarding entry for a station, keyed by its 48-bit MAC address and 12-bit VLAN id. From the key it forms a 60-bit seed and folds it into an 11-bit bucket index. The fold has two variants, chosen per request: a plain XOR of the seed slices, and an alternate form in which three slices are rotated before the XOR. Each bucket holds four entries in an external synchronous SRAM with one cycle of read latency. The engine reads the ways of the bucket one at a time over the SRAM port.

A lookup reports whether the key is present and returns the lowest matching way together with its stored port, static bit, age and flag bits. A learn either refreshes the way that already holds the key or writes the key into the first free way. If all four ways hold other keys, it reports that the bucket is full and writes nothing. Entries carry no valid bit: occupancy is inferred from their age, static, multicast and flag bits.

The controller is a five-state machine. `ST_IDLE` accepts a request (transition *accept*) and moves to `ST_FETCH`. `ST_FETCH` issues a read of the current way and always moves to `ST_CHECK` (*issue*). `ST_CHECK` examines the returned word and takes one of three exits:
- *next-way*: back to `ST_FETCH` for the following way.
- *commit*: to `ST_WRITE`, for a learn.
- *finish*: to `ST_DONE`.

`ST_WRITE` drives the SRAM write and moves to `ST_DONE` (*retire*). `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE` (*release*).

Top module: `l2_bucket_engine`

## Requirements
- R1: In plain mode (`hash_alt`=0) the bucket index is the XOR of seed bits 10:0, 21:11, 32:22, 43:33, 54:44 and 63:55 (zero-extended). The seed is `{mac, vid}`, i.e. the MAC shifted left by 12 with the VID in bits 11:0.
- R2: In alternate mode (`hash_alt`=1) the slices at 21:11, 43:33 and 54:44 are rotated right by 5, 6 and 7 bits respectively before the same XOR. `hash_alt` is sampled when a request is accepted.
- R3: Every SRAM access uses address `{1'b0, 1'b0, index[10:0], way[1:0]}`. Bit 14 is 0. Ways are read in increasing order starting at way 0, with at least one cycle between reads.
- R4: An entry is occupied when word0 bits 22:18 hold any 1, or word1 bit 31, 30 or 28 is 1. Word1 bit 29 alone, or age bit 17 alone, does not make an entry occupied.
- R5: A lookup hits on the lowest occupied way whose MAC and VID equal the key. It stops reading there and returns the way and the fields of that way:
  - port: word0 16:12
  - static: word0 bit 19
  - age: word0 18:17
  - `res_flags`: word1 31:28, giving {SA-block, DA-block, suspended, next-hop} from bit 3 down to bit 0
- R6: A lookup with no occupied matching way reports `res_hit`=0 and `res_full`=0 with all result fields zero, after reading all four ways. It performs no write.
- R7: A learn of a new key writes one entry to the lowest unoccupied way and reports `res_hit`=0 with that way. The entry is packed as follows:
  - word0 = VID in 11:0, port in 16:12, age 2'b11 in 18:17, static in bit 19, other bits 0
  - word1 = MAC[47:20] in 27:0, flags 0
  - word2 = MAC[19:0] in 31:12, VID in 11:0
  - `mem_wdata` = {word2, word1, word0}
- R8: A learn whose key already occupies a way rewrites that lowest matching way with the new port and static bit and reports `res_hit`=1.
- R9: A learn into a bucket whose four ways are occupied by other keys performs no write. It reports `res_full`=1 with `res_hit`=0.
- R10: `req_ready` is high only in `ST_IDLE`. A `req_valid` seen while busy is ignored, and the SRAM is quiet while idle.
- R11: After reset `req_ready`=1, `done`=0, `mem_rd`=0 and `mem_wr`=0.
- R12: `done` is a single-cycle pulse. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hash_alt | input | 1 | Hash variant select: 0 plain fold, 1 rotated fold |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_learn | input | 1 | 0 lookup, 1 learn |
| req_mac | input | 48 | Station MAC address |
| req_vid | input | 12 | VLAN id |
| req_port | input | 5 | Port to store on learn |
| req_static | input | 1 | Static bit to store on learn |
| req_ready | output | 1 | Engine idle |
| mem_rd | output | 1 | SRAM read strobe |
| mem_wr | output | 1 | SRAM write strobe |
| mem_addr | output | 15 | SRAM word address |
| mem_wdata | output | 96 | Entry to write {word2, word1, word0} |
| mem_rdata | input | 96 | Entry read, valid the cycle after `mem_rd` |
| done | output | 1 | Result valid pulse |
| res_hit | output | 1 | Key was present |
| res_full | output | 1 | Learn found no free way |
| res_way | output | 2 | Matching or written way |
| res_port | output | 5 | Port of matching or written entry |
| res_static | output | 1 | Static bit of that entry |
| res_age | output | 2 | Age field of that entry |
| res_flags | output | 4 | {SA-block, DA-block, suspended, next-hop} |

## Verification
The hardest situations are buckets holding several entries with different occupancy, because ordinary learns fill ways strictly in order. Two layouts are needed: a matching key left in a lower way with no occupancy bits, and an entry that is occupied only through its next-hop bit. The bench owns the SRAM model, so it writes such bucket images directly at the index its own hash model predicts. It then issues lookups and learns against them, covering the lowest-way rule, the false-occupancy patterns and a bucket filled by four foreign keys. A request raised in mid-operation checks that a busy engine ignores new work.

// File: rtl/l2b_pkg.sv
package l2b_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_WRITE,
        ST_DONE
    } l2b_state_e;

    // Right-rotate amount applied to each seed slice in the alternate fold.
    function automatic int slice_spin(input int idx);
        case (idx)
            1:       return 5;
            3:       return 6;
            4:       return 7;
            default: return 0;
        endcase
    endfunction

    localparam int FLAG_W = 4;
    localparam int AGE_W  = 2;

endpackage

// File: rtl/l2b_hash.sv
module l2b_hash #(
    parameter int MAC_W  = 48,
    parameter int VID_W  = 12,
    parameter int HASH_W = 11
) (
    input  logic [MAC_W-1:0]  mac,
    input  logic [VID_W-1:0]  vid,
    input  logic              alt,
    output logic [HASH_W-1:0] index
);
    import l2b_pkg::*;

    localparam int SEED_W = MAC_W + VID_W;
    localparam int NSLICE = (SEED_W + HASH_W - 1) / HASH_W;
    localparam int PAD_W  = NSLICE * HASH_W;

    logic [PAD_W-1:0]  seed_pad;
    logic [HASH_W-1:0] lane [NSLICE];

    always_comb begin
        seed_pad = '0;
        seed_pad[SEED_W-1:0] = {mac, vid};
    end

    for (genvar i = 0; i < NSLICE; i++) begin : g_lane
        localparam int K = slice_spin(i);
        logic [HASH_W-1:0] raw;
        logic [HASH_W-1:0] spun;
        assign raw = seed_pad[i*HASH_W +: HASH_W];
        if (K == 0) begin : g_flat
            assign spun = raw;
        end else begin : g_turn
            assign spun = {raw[K-1:0], raw[HASH_W-1:K]};
        end
        assign lane[i] = alt ? spun : raw;
    end

    always_comb begin
        index = '0;
        for (int i = 0; i < NSLICE; i++) begin
            index = index ^ lane[i];
        end
    end

endmodule

// File: rtl/l2b_entry_view.sv
module l2b_entry_view #(
    parameter int MAC_W  = 48,
    parameter int VID_W  = 12,
    parameter int PORT_W = 5,
    parameter int WORD_W = 32
) (
    input  logic [3*WORD_W-1:0] entry,
    input  logic [MAC_W-1:0]    key_mac,
    input  logic [VID_W-1:0]    key_vid,
    output logic                occupied,
    output logic                matched,
    output logic [PORT_W-1:0]   port,
    output logic                stat,
    output logic [1:0]          age,
    output logic [3:0]          flags
);
    localparam int PORT_LO  = VID_W;
    localparam int AGE_LO   = PORT_LO + PORT_W;
    localparam int STAT_BIT = AGE_LO + 2;
    localparam int OCC_LO   = AGE_LO + 1;
    localparam int OCC_HI   = AGE_LO + 5;
    localparam int MLO_W    = WORD_W - VID_W;
    localparam int MHI_W    = MAC_W - MLO_W;

    logic [WORD_W-1:0] w0, w1, w2;
    logic [MAC_W-1:0]  stored_mac;
    logic              unused_bits;

    assign w0 = entry[WORD_W-1:0];
    assign w1 = entry[2*WORD_W-1:WORD_W];
    assign w2 = entry[3*WORD_W-1:2*WORD_W];

    assign stored_mac = {w1[MHI_W-1:0], w2[WORD_W-1:VID_W]};

    assign occupied = (|w0[OCC_HI:OCC_LO]) | w1[WORD_W-1] | w1[WORD_W-2] | w1[WORD_W-4];
    assign matched  = occupied && (stored_mac == key_mac) && (w0[VID_W-1:0] == key_vid);

    assign port  = w0[PORT_LO +: PORT_W];
    assign age   = w0[AGE_LO +: 2];
    assign stat  = w0[STAT_BIT];
    assign flags = w1[WORD_W-1 -: 4];

    assign unused_bits = ^{w0[WORD_W-1:OCC_HI+1], w2[VID_W-1:0]};

endmodule

// File: rtl/l2b_entry_pack.sv
module l2b_entry_pack #(
    parameter int MAC_W  = 48,
    parameter int VID_W  = 12,
    parameter int PORT_W = 5,
    parameter int WORD_W = 32
) (
    input  logic [MAC_W-1:0]    mac,
    input  logic [VID_W-1:0]    vid,
    input  logic [PORT_W-1:0]   port,
    input  logic                stat,
    output logic [3*WORD_W-1:0] entry
);
    localparam int PORT_LO  = VID_W;
    localparam int AGE_LO   = PORT_LO + PORT_W;
    localparam int STAT_BIT = AGE_LO + 2;
    localparam int MLO_W    = WORD_W - VID_W;
    localparam int MHI_W    = MAC_W - MLO_W;

    logic [WORD_W-1:0] w0, w1, w2;

    always_comb begin
        w0 = '0;
        w0[VID_W-1:0]       = vid;
        w0[PORT_LO +: PORT_W] = port;
        w0[AGE_LO +: 2]      = 2'b11;
        w0[STAT_BIT]         = stat;

        w1 = '0;
        w1[MHI_W-1:0] = mac[MAC_W-1:MLO_W];

        w2 = '0;
        w2[WORD_W-1:VID_W] = mac[MLO_W-1:0];
        w2[VID_W-1:0]      = vid;
    end

    assign entry = {w2, w1, w0};

endmodule

// File: rtl/l2_bucket_engine.sv
module l2_bucket_engine #(
    parameter int MAC_W  = 48,
    parameter int VID_W  = 12,
    parameter int PORT_W = 5,
    parameter int HASH_W = 11,
    parameter int WAYS   = 4,
    parameter int WORD_W = 32,
    parameter int WAY_W  = $clog2(WAYS),
    parameter int ADDR_W = HASH_W + WAY_W + 2,
    parameter int ENT_W  = 3 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hash_alt,
    input  logic              req_valid,
    input  logic              req_learn,
    input  logic [MAC_W-1:0]  req_mac,
    input  logic [VID_W-1:0]  req_vid,
    input  logic [PORT_W-1:0] req_port,
    input  logic              req_static,
    output logic              req_ready,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ENT_W-1:0]  mem_wdata,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              done,
    output logic              res_hit,
    output logic              res_full,
    output logic [WAY_W-1:0]  res_way,
    output logic [PORT_W-1:0] res_port,
    output logic              res_static,
    output logic [1:0]        res_age,
    output logic [3:0]        res_flags
);
    import l2b_pkg::*;

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);
    localparam int               UPPER_W  = ADDR_W - HASH_W - WAY_W;

    l2b_state_e state, state_nx;

    logic                accept;
    logic [HASH_W-1:0]   hash_now;
    logic [HASH_W-1:0]   base_q;
    logic [MAC_W-1:0]    key_mac;
    logic [VID_W-1:0]    key_vid;
    logic [PORT_W-1:0]   key_port;
    logic                key_static;
    logic                key_learn;
    logic                key_alt;
    logic [WAY_W-1:0]    way_q;
    logic [WAY_W-1:0]    tgt_q;
    logic                free_seen;
    logic [WAY_W-1:0]    free_way;

    logic                v_occ, v_match, v_stat;
    logic [PORT_W-1:0]   v_port;
    logic [1:0]          v_age;
    logic [3:0]          v_flags;

    logic                last_way;
    logic                learn_has_slot;
    logic [WAY_W-1:0]    learn_slot;

    // ---------------- hash of the incoming key ----------------
    l2b_hash #(
        .MAC_W (MAC_W),
        .VID_W (VID_W),
        .HASH_W(HASH_W)
    ) u_hash (
        .mac  (req_mac),
        .vid  (req_vid),
        .alt  (hash_alt),
        .index(hash_now)
    );

    // ---------------- decode of the way just read ----------------
    l2b_entry_view #(
        .MAC_W (MAC_W),
        .VID_W (VID_W),
        .PORT_W(PORT_W),
        .WORD_W(WORD_W)
    ) u_view (
        .entry   (mem_rdata),
        .key_mac (key_mac),
        .key_vid (key_vid),
        .occupied(v_occ),
        .matched (v_match),
        .port    (v_port),
        .stat    (v_stat),
        .age     (v_age),
        .flags   (v_flags)
    );

    // ---------------- packing of the entry to learn ----------------
    l2b_entry_pack #(
        .MAC_W (MAC_W),
        .VID_W (VID_W),
        .PORT_W(PORT_W),
        .WORD_W(WORD_W)
    ) u_pack (
        .mac  (key_mac),
        .vid  (key_vid),
        .port (key_port),
        .stat (key_static),
        .entry(mem_wdata)
    );

    assign accept         = req_valid && req_ready;
    assign last_way       = (way_q == LAST_WAY);
    assign learn_has_slot = free_seen || !v_occ;
    assign learn_slot     = free_seen ? free_way : way_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------- transitions ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_FETCH;          // accept
            ST_FETCH: state_nx = ST_CHECK;                      // issue
            ST_CHECK: begin
                if (v_match) begin
                    state_nx = key_learn ? ST_WRITE : ST_DONE;  // commit / finish
                end else if (!last_way) begin
                    state_nx = ST_FETCH;                        // next-way
                end else if (key_learn && learn_has_slot) begin
                    state_nx = ST_WRITE;                        // commit
                end else begin
                    state_nx = ST_DONE;                         // finish
                end
            end
            ST_WRITE: state_nx = ST_DONE;                       // retire
            ST_DONE:  state_nx = ST_IDLE;                       // release
            default:  state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs of the state machine ----------------
    always_comb begin
        req_ready = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        done      = 1'b0;
        mem_addr  = {{UPPER_W{1'b0}}, base_q, way_q};
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: mem_rd    = 1'b1;
            ST_CHECK: ;
            ST_WRITE: begin
                mem_wr   = 1'b1;
                mem_addr = {{UPPER_W{1'b0}}, base_q, tgt_q};
            end
            ST_DONE:  done      = 1'b1;
            default:  ;
        endcase
    end

    // ---------------- key capture, way walk and result ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q     <= '0;
            key_mac    <= '0;
            key_vid    <= '0;
            key_port   <= '0;
            key_static <= 1'b0;
            key_learn  <= 1'b0;
            key_alt    <= 1'b0;
            way_q      <= '0;
            tgt_q      <= '0;
            free_seen  <= 1'b0;
            free_way   <= '0;
            res_hit    <= 1'b0;
            res_full   <= 1'b0;
            res_way    <= '0;
            res_port   <= '0;
            res_static <= 1'b0;
            res_age    <= '0;
            res_flags  <= '0;
        end else begin
            if (state == ST_IDLE && accept) begin
                base_q     <= hash_now;
                key_mac    <= req_mac;
                key_vid    <= req_vid;
                key_port   <= req_port;
                key_static <= req_static;
                key_learn  <= req_learn;
                key_alt    <= hash_alt;
                way_q      <= '0;
                tgt_q      <= '0;
                free_seen  <= 1'b0;
                free_way   <= '0;
                res_hit    <= 1'b0;
                res_full   <= 1'b0;
                res_way    <= '0;
                res_port   <= '0;
                res_static <= 1'b0;
                res_age    <= '0;
                res_flags  <= '0;
            end
            if (state == ST_CHECK) begin
                if (!v_occ && !free_seen) begin
                    free_seen <= 1'b1;
                    free_way  <= way_q;
                end
                if (v_match) begin
                    res_hit <= 1'b1;
                    res_way <= way_q;
                    tgt_q   <= way_q;
                    if (key_learn) begin
                        res_port   <= key_port;
                        res_static <= key_static;
                        res_age    <= 2'b11;
                        res_flags  <= '0;
                    end else begin
                        res_port   <= v_port;
                        res_static <= v_stat;
                        res_age    <= v_age;
                        res_flags  <= v_flags;
                    end
                end else if (!last_way) begin
                    way_q <= way_q + WAY_W'(1);
                end else if (key_learn) begin
                    if (learn_has_slot) begin
                        tgt_q      <= learn_slot;
                        res_way    <= learn_slot;
                        res_port   <= key_port;
                        res_static <= key_static;
                        res_age    <= 2'b11;
                    end else begin
                        res_full <= 1'b1;
                    end
                end
            end
        end
    end

    // ---------------- assertions ----------------
    p_rdwr_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_first_way_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd && mem_addr[WAY_W-1:0] == '0
                                      && mem_addr[ADDR_W-1] == 1'b0));

    p_read_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    p_ready_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    p_full_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_full) |-> !$past(mem_wr));

    p_hit_full_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(res_hit && res_full));

    p_write_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(state) == ST_CHECK && key_learn));

    p_alt_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(key_alt));

endmodule

// File: tb/l2_bucket_engine_test.sv
module l2_bucket_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hash_alt = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_learn = 1'b0;
    logic [47:0] req_mac = '0;
    logic [11:0] req_vid = '0;
    logic [4:0]  req_port = '0;
    logic        req_static = 1'b0;
    logic        req_ready;
    logic        mem_rd, mem_wr;
    logic [14:0] mem_addr;
    logic [95:0] mem_wdata;
    logic [95:0] mem_rdata = '0;
    logic        done, res_hit, res_full, res_static;
    logic [1:0]  res_way, res_age;
    logic [4:0]  res_port;
    logic [3:0]  res_flags;

    int checks = 0;
    int errors = 0;
    bit op_active = 1'b0;
    bit finished = 1'b0;

    logic [95:0] tbl [int];

    always #4 clk = ~clk;

    l2_bucket_engine uut (
        .clk(clk), .rst_n(rst_n), .hash_alt(hash_alt),
        .req_valid(req_valid), .req_learn(req_learn),
        .req_mac(req_mac), .req_vid(req_vid), .req_port(req_port),
        .req_static(req_static), .req_ready(req_ready),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .res_hit(res_hit), .res_full(res_full),
        .res_way(res_way), .res_port(res_port), .res_static(res_static),
        .res_age(res_age), .res_flags(res_flags)
    );

    // SRAM model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= tbl.exists(int'(mem_addr)) ? tbl[int'(mem_addr)] : '0;
        if (mem_wr) tbl[int'(mem_addr)] = mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // SRAM must stay quiet while no operation is running (R10)
    always @(negedge clk) begin
        if (rst_n && !op_active && (mem_rd || mem_wr)) begin
            chk(1'b0, "R10", "access while idle", {94'd0, mem_rd, mem_wr}, '0);
        end
    end

    function automatic int ref_index(input logic [47:0] mac, input logic [11:0] vid, input bit alt);
        longint unsigned s;
        int a, b, c, d, e, f;
        s = {4'd0, mac, vid};
        a = int'(s & 64'h7ff);
        b = int'((s >> 11) & 64'h7ff);
        c = int'((s >> 22) & 64'h7ff);
        d = int'((s >> 33) & 64'h7ff);
        e = int'((s >> 44) & 64'h7ff);
        f = int'((s >> 55) & 64'h1ff);
        if (alt) begin
            b = ((b % 32) * 64) + (b / 32);
            d = ((d % 64) * 32) + (d / 64);
            e = ((e % 128) * 16) + (e / 128);
        end
        return a ^ b ^ c ^ d ^ e ^ f;
    endfunction

    function automatic logic [95:0] mk_entry(input logic [47:0] mac, input logic [11:0] vid,
                                             input logic [4:0] port, input bit stat,
                                             input logic [1:0] age, input logic [3:0] flags);
        logic [31:0] w0, w1, w2;
        w0 = 32'd0;
        w0[11:0]  = vid;
        w0[16:12] = port;
        w0[18:17] = age;
        w0[19]    = stat;
        w1 = {flags, mac[47:20]};
        w2 = {mac[19:0], vid};
        return {w2, w1, w0};
    endfunction

    function automatic bit is_occ(input logic [95:0] e);
        return (e[22:18] != 5'd0) || e[63] || e[62] || e[60];
    endfunction

    task automatic put(input logic [47:0] mac, input logic [11:0] vid, input bit alt,
                       input int way, input logic [95:0] e);
        tbl[ref_index(mac, vid, alt) * 4 + way] = e;
    endtask

    task automatic run_op(input bit learn, input logic [47:0] mac, input logic [11:0] vid,
                          input bit alt, input logic [4:0] port, input bit stat,
                          input string tag, input bit poke);
        int base, reads, writes, found, freew, exp_reads, wway;
        bit e_hit, e_full, e_wr, got;
        logic [1:0] e_way, e_age;
        logic [4:0] e_port;
        logic e_stat;
        logic [3:0] e_flags;
        logic [95:0] ent, fent, wexp;
        base = ref_index(mac, vid, alt);
        found = -1; freew = -1; exp_reads = 0; fent = '0;
        for (int w = 0; w < 4; w++) begin
            ent = tbl.exists(base * 4 + w) ? tbl[base * 4 + w] : '0;
            exp_reads++;
            if (is_occ(ent) && {ent[59:32], ent[95:76]} == mac && ent[11:0] == vid) begin
                found = w; fent = ent;
                break;
            end
            if (!is_occ(ent) && freew < 0) freew = w;
        end
        e_hit = 0; e_full = 0; e_wr = 0; e_way = 0; e_port = 0; e_stat = 0;
        e_age = 0; e_flags = 0; wway = 0;
        wexp = mk_entry(mac, vid, port, stat, 2'b11, 4'd0);
        if (!learn) begin
            if (found >= 0) begin
                e_hit = 1; e_way = 2'(found); e_port = fent[16:12]; e_stat = fent[19];
                e_age = fent[18:17]; e_flags = fent[63:60];
            end
        end else begin
            if (found >= 0) begin e_hit = 1; wway = found; e_wr = 1; end
            else if (freew >= 0) begin wway = freew; e_wr = 1; end
            else e_full = 1;
            if (e_wr) begin e_way = 2'(wway); e_port = port; e_stat = stat; e_age = 2'b11; end
        end

        @(negedge clk);
        op_active = 1'b1;
        req_valid = 1'b1; req_learn = learn; req_mac = mac; req_vid = vid;
        req_port = port; req_static = stat; hash_alt = alt;
        reads = 0; writes = 0; got = 0;
        for (int cyc = 0; cyc < 40 && !got; cyc++) begin
            @(negedge clk);
            if (cyc == 0) req_valid = 1'b0;
            if (poke && cyc == 1) begin
                chk(req_ready == 1'b0, "R10", {tag, " ready while busy"}, {95'd0, req_ready}, '0);
                req_valid = 1'b1; req_learn = 1'b1; req_mac = 48'hdead_beef_0001;
                req_vid = 12'h777; hash_alt = ~alt;
            end
            if (poke && cyc == 2) req_valid = 1'b0;
            if (mem_rd) begin
                chk(mem_addr == 15'(base * 4 + reads), alt ? "R2" : "R1",
                    {tag, " read address"}, {81'd0, mem_addr}, 96'(base * 4 + reads));
                reads++;
            end
            if (mem_wr) begin
                chk(mem_addr == 15'(base * 4 + wway), "R7", {tag, " write address"},
                    {81'd0, mem_addr}, 96'(base * 4 + wway));
                chk(mem_wdata == wexp, "R7", {tag, " write data"}, mem_wdata, wexp);
                writes++;
            end
            if (done) begin
                got = 1;
                chk(res_hit == e_hit, learn ? "R8" : "R5", {tag, " hit"}, {95'd0, res_hit}, {95'd0, e_hit});
                chk(res_full == e_full, "R9", {tag, " full"}, {95'd0, res_full}, {95'd0, e_full});
                chk({res_way, res_port, res_static, res_age, res_flags} ==
                    {e_way, e_port, e_stat, e_age, e_flags}, learn ? "R7" : "R5", {tag, " fields"},
                    {82'd0, res_way, res_port, res_static, res_age, res_flags},
                    {82'd0, e_way, e_port, e_stat, e_age, e_flags});
            end
        end
        chk(got, "R12", {tag, " completion"}, {95'd0, got}, 96'd1);
        chk(reads == exp_reads, "R3", {tag, " read count"}, 96'(reads), 96'(exp_reads));
        chk(writes == int'(e_wr), learn ? "R9" : "R6", {tag, " write count"}, 96'(writes), 96'(e_wr));
        op_active = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R12", {tag, " done single pulse"}, {95'd0, done}, '0);
        chk(req_ready == 1'b1, "R10", {tag, " ready after done"}, {95'd0, req_ready}, 96'd1);
    endtask

    localparam logic [47:0] MA = 48'h0012_3456_789a;
    localparam logic [47:0] MB = 48'h00a0_c9f0_0102;
    localparam logic [47:0] MC = 48'h3c97_0e11_5aa4;
    localparam logic [47:0] MD = 48'h0800_2700_ffee;
    localparam logic [47:0] MX = 48'h0055_aa55_aa00;

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0 && mem_rd == 1'b0 && mem_wr == 1'b0, "R11",
            "reset state", {92'd0, req_ready, done, mem_rd, mem_wr}, 96'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R11", "after release", {94'd0, req_ready, done}, 96'h2);

        // R1 R6: empty bucket lookup misses after four reads
        run_op(0, MA, 12'h00a, 0, 5'd0, 0, "R6 empty lookup", 0);
        // R7: learn then R5 lookup
        run_op(1, MA, 12'h00a, 0, 5'd3, 0, "R7 learn new", 0);
        run_op(0, MA, 12'h00a, 0, 5'd0, 0, "R5 lookup learned", 1);

        // R4 R7: way0 foreign, way1 only suspended+age bit17 (free), way2 foreign
        put(MB, 12'h010, 0, 0, mk_entry(MX, 12'h010, 5'd1, 0, 2'b10, 4'd0));
        put(MB, 12'h010, 0, 1, mk_entry(MX, 12'h011, 5'd2, 0, 2'b01, 4'b0010));
        put(MB, 12'h010, 0, 2, mk_entry(MX, 12'h012, 5'd3, 1, 2'b00, 4'd0));
        run_op(1, MB, 12'h010, 0, 5'd9, 1, "R4 learn skips to free way", 0);
        run_op(0, MB, 12'h010, 0, 5'd0, 0, "R5 lookup way1", 0);
        // R8: relearn overwrites with new port
        run_op(1, MB, 12'h010, 0, 5'd17, 0, "R8 relearn", 0);
        run_op(0, MB, 12'h010, 0, 5'd0, 0, "R8 lookup after relearn", 0);

        // R5 R6 R4: way0 matching but unoccupied, way1 occupied only by next-hop, way3 also matching
        put(MC, 12'h123, 0, 0, mk_entry(MC, 12'h123, 5'd9, 0, 2'b00, 4'd0));
        put(MC, 12'h123, 0, 1, mk_entry(MC, 12'h123, 5'd7, 0, 2'b00, 4'b0001));
        put(MC, 12'h123, 0, 3, mk_entry(MC, 12'h123, 5'd12, 1, 2'b01, 4'b1100));
        run_op(0, MC, 12'h123, 0, 5'd0, 0, "R5 lowest occupied match", 0);

        // R9: four foreign occupied ways
        for (int w = 0; w < 4; w++)
            put(MD, 12'hfff, 0, w, mk_entry(MX, 12'(w), 5'(w), 0, 2'b00, 4'b1000));
        run_op(1, MD, 12'hfff, 0, 5'd4, 0, "R9 bucket full", 0);
        run_op(0, MD, 12'hfff, 0, 5'd0, 0, "R6 miss in full bucket", 0);

        // R2: alternate fold
        run_op(1, MC, 12'h5a5, 1, 5'd21, 1, "R2 learn alt", 0);
        run_op(0, MC, 12'h5a5, 1, 5'd0, 0, "R2 lookup alt", 1);
        run_op(0, MC, 12'h5a5, 0, 5'd0, 0, "R1 lookup plain", 0);

        // mixed traffic over a small key pool
        lfsr = 16'hace1;
        for (int n = 0; n < 30; n++) begin
            logic [47:0] m;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            m = {32'h0200_0000, 13'd0, lfsr[2:0]} ^ {lfsr, lfsr, lfsr};
            if (lfsr[5]) m = {45'h1234_5678_9ab, lfsr[2:0]};
            run_op(lfsr[3], m, {9'd0, lfsr[8:6]}, lfsr[4], lfsr[15:11], lfsr[9],
                   "R1 R2 mixed", lfsr[10]);
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule